// File: doc/BRIEF.md
# Floating-Point Sign, Min/Max, Compare and Classify Unit

This unit executes the non-arithmetic floating-point operations of a scalar FP pipeline on raw IEEE-754 bit patterns, in either single or double precision. It builds sign-injected values, selects the minimum or maximum of two operands, compares two operands, classifies one operand into a ten-way mask, and moves an FP register image into the integer file. Results meant for the FP register file assert `fp_wr`. Results meant for the integer register file assert `int_wr`. An invalid-operation flag reports any case that needs one.

Single-precision operands occupy bits 31:0 of the 64-bit source buses, and bits 63:32 are don't-care. The operation is chosen by a 2-bit group code and a 3-bit sub-select. The datapath is combinational. One output register stage presents each result on the clock edge after `in_valid` was sampled high.

Top module: `fpm_unit`

## Requirements
- R1: With op=3 and sub=1, the result is a one-hot mask of the class of src_a, zero-extended, with int_wr set and no flag. The bits are: 0 negative infinity, 1 negative normal, 2 negative subnormal, 3 negative zero, 4 positive zero, 5 positive subnormal, 6 positive normal, 7 positive infinity, 8 signaling NaN, 9 quiet NaN. A NaN is quiet when the top mantissa bit is 1, and signaling when that bit is 0 and the mantissa is nonzero.
- R2: With op=2 and sub=2 (equal), the result is 1 when the operands are numerically equal, and +0 equals -0. The result is 0 if either operand is a NaN. The flag is raised only when an operand is a signaling NaN.
- R3: With op=2, sub=1 gives less-than and sub=0 gives less-or-equal. Both return 0 and raise the flag when either operand is any NaN. Neither orders -0 below +0.
- R4: With op=1, sub=0 selects the minimum and sub=1 the maximum, with -0 ordered below +0. When exactly one operand is a NaN, the other operand is returned. The flag is raised if either operand is a signaling NaN.
- R5: When both min/max operands are NaN, the result is the canonical quiet NaN: 0x7FC00000 for single, 0x7FF8000000000000 for double.
- R6: With op=0, the result is src_a with its sign replaced. sub=0 uses the sign of src_b, sub=1 uses its inverse, and sub=2 uses the XOR of both signs. All other bits, including NaN payloads, pass through unchanged, and the flag is never raised.
- R7: With dbl=0, only bits 31:0 of each source are used. Every FP-destination result has bits 63:32 equal to zero.
- R8: Groups 0 and 1 write only the FP destination (fp_wr). Groups 2 and 3 write only the integer destination (int_wr). Compare results are 0 or 1, zero-extended.
- R9: With op=3 and sub=0, src_a is moved to the integer destination. In single precision, bit 31 is sign-extended into bits 63:32. In double precision, all 64 bits are copied.
- R10: An unused sub-select for a group produces result 0, no write and no flag. The unused codes are sub 3 to 7 for groups 0 and 2, sub 2 to 7 for groups 1 and 3.
- R11: The outputs appear one clock after in_valid is sampled high, together with out_valid. While out_valid is low, fp_wr, int_wr and flag_nv are low. Reset clears every output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation request this cycle |
| dbl | input | 1 | 1 = double precision, 0 = single |
| op | input | 2 | Group: 0 sign inject, 1 min/max, 2 compare, 3 classify/move |
| sub | input | 3 | Sub-select within the group |
| src_a | input | 64 | First operand bits |
| src_b | input | 64 | Second operand bits |
| out_valid | output | 1 | Result presented this cycle |
| fp_wr | output | 1 | Result goes to the FP destination |
| int_wr | output | 1 | Result goes to the integer destination |
| result | output | 64 | Result bits |
| flag_nv | output | 1 | Invalid-operation flag |

## Verification
The invalid flag and a returned value can each stem from the same NaN in a single cycle. A signaling NaN fed to min/max must produce both the other operand and a raised flag. A quiet NaN in an equality compare must produce a zero result with the flag held low. The bench provokes these collisions by biasing both operands towards NaNs, zeros of either sign, infinities and copies of each other. Each cycle is judged by comparing the result, destination selects and flag together against a reference built on signed ordering keys.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

  localparam int XW      = 64;
  localparam int SP_EXP  = 8;
  localparam int SP_MAN  = 23;
  localparam int DP_EXP  = 11;
  localparam int DP_MAN  = 52;
  localparam int SP_W    = SP_EXP + SP_MAN + 1;
  localparam int MAG_W   = XW - 1;
  localparam int CLS_W   = 10;
  localparam int SUB_W   = 3;

  localparam logic [XW-1:0] CANON_SP = {{(XW-SP_W){1'b0}}, 32'h7FC0_0000};
  localparam logic [XW-1:0] CANON_DP = 64'h7FF8_0000_0000_0000;

  typedef enum logic [1:0] {
    GRP_SGNJ   = 2'd0,
    GRP_MINMAX = 2'd1,
    GRP_CMP    = 2'd2,
    GRP_CLASS  = 2'd3
  } grp_e;

  typedef struct packed {
    logic             sgn;
    logic             is_inf;
    logic             is_zero;
    logic             is_sub;
    logic             is_norm;
    logic             is_snan;
    logic             is_qnan;
    logic [MAG_W-1:0] mag;
  } opinfo_t;

endpackage

// File: rtl/fpm_unpack.sv
module fpm_unpack
  import fpm_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic [EXP_W+MAN_W:0] bits,
  output opinfo_t              info
);
  localparam int TOP = EXP_W + MAN_W;

  logic [EXP_W-1:0] ex;
  logic [MAN_W-1:0] mn;
  logic             ex_ones, ex_zero, mn_zero, nan;

  assign ex      = bits[TOP-1:MAN_W];
  assign mn      = bits[MAN_W-1:0];
  assign ex_ones = &ex;
  assign ex_zero = ~|ex;
  assign mn_zero = ~|mn;
  assign nan     = ex_ones & ~mn_zero;

  always_comb begin
    info         = '0;
    info.sgn     = bits[TOP];
    info.is_inf  = ex_ones & mn_zero;
    info.is_zero = ex_zero & mn_zero;
    info.is_sub  = ex_zero & ~mn_zero;
    info.is_norm = ~ex_ones & ~ex_zero;
    info.is_qnan = nan & mn[MAN_W-1];
    info.is_snan = nan & ~mn[MAN_W-1];
    info.mag     = MAG_W'(bits[TOP-1:0]);
  end

endmodule

// File: rtl/fpm_order.sv
module fpm_order
  import fpm_pkg::*;
(
  input  opinfo_t ia,
  input  opinfo_t ib,
  output logic    tot_lt,
  output logic    num_lt,
  output logic    num_eq
);
  logic mag_lt, mag_gt, mag_eq, both_zero;

  assign mag_lt    = ia.mag < ib.mag;
  assign mag_gt    = ia.mag > ib.mag;
  assign mag_eq    = ia.mag == ib.mag;
  assign both_zero = ia.is_zero & ib.is_zero;

  always_comb begin
    if (ia.sgn != ib.sgn) tot_lt = ia.sgn;
    else if (!ia.sgn)     tot_lt = mag_lt;
    else                  tot_lt = mag_gt;
  end

  assign num_lt = tot_lt & ~both_zero;
  assign num_eq = both_zero | ((ia.sgn == ib.sgn) & mag_eq);

endmodule

// File: rtl/fpm_sgnj.sv
module fpm_sgnj
  import fpm_pkg::*;
(
  input  logic             dbl,
  input  logic [SUB_W-1:0] sub,
  input  logic [XW-1:0]    a,
  input  logic             sgn_a,
  input  logic             sgn_b,
  output logic [XW-1:0]    res,
  output logic             ok
);
  logic new_sgn;

  always_comb begin
    ok      = 1'b1;
    new_sgn = sgn_b;
    case (sub)
      3'd0:    new_sgn = sgn_b;
      3'd1:    new_sgn = ~sgn_b;
      3'd2:    new_sgn = sgn_a ^ sgn_b;
      default: ok = 1'b0;
    endcase
    if (dbl) res = {new_sgn, a[XW-2:0]};
    else     res = {{(XW-SP_W){1'b0}}, new_sgn, a[SP_W-2:0]};
    if (!ok) res = '0;
  end

endmodule

// File: rtl/fpm_minmax.sv
module fpm_minmax
  import fpm_pkg::*;
(
  input  logic             dbl,
  input  logic [SUB_W-1:0] sub,
  input  opinfo_t          ia,
  input  opinfo_t          ib,
  input  logic [XW-1:0]    a_fp,
  input  logic [XW-1:0]    b_fp,
  input  logic             tot_lt,
  output logic [XW-1:0]    res,
  output logic             nv,
  output logic             ok
);
  logic a_nan, b_nan, pick_a;

  assign a_nan = ia.is_snan | ia.is_qnan;
  assign b_nan = ib.is_snan | ib.is_qnan;

  always_comb begin
    ok     = (sub == 3'd0) | (sub == 3'd1);
    pick_a = (sub == 3'd0) ? tot_lt : ~tot_lt;
    if (a_nan && b_nan) res = dbl ? CANON_DP : CANON_SP;
    else if (a_nan)     res = b_fp;
    else if (b_nan)     res = a_fp;
    else                res = pick_a ? a_fp : b_fp;
    nv = ia.is_snan | ib.is_snan;
    if (!ok) begin
      res = '0;
      nv  = 1'b0;
    end
  end

endmodule

// File: rtl/fpm_unit.sv
module fpm_unit
  import fpm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             dbl,
  input  logic [1:0]       op,
  input  logic [SUB_W-1:0] sub,
  input  logic [XW-1:0]    src_a,
  input  logic [XW-1:0]    src_b,
  output logic             out_valid,
  output logic             fp_wr,
  output logic             int_wr,
  output logic [XW-1:0]    result,
  output logic             flag_nv
);

  opinfo_t       info [2];
  logic [XW-1:0] fpv  [2];

  for (genvar gi = 0; gi < 2; gi++) begin : g_opnd
    logic [XW-1:0] raw;
    opinfo_t       inf_sp, inf_dp;
    assign raw = (gi == 0) ? src_a : src_b;
    fpm_unpack #(.EXP_W(SP_EXP), .MAN_W(SP_MAN)) u_sp (
      .bits(raw[SP_W-1:0]), .info(inf_sp));
    fpm_unpack #(.EXP_W(DP_EXP), .MAN_W(DP_MAN)) u_dp (
      .bits(raw), .info(inf_dp));
    assign info[gi] = dbl ? inf_dp : inf_sp;
    assign fpv[gi]  = dbl ? raw : {{(XW-SP_W){1'b0}}, raw[SP_W-1:0]};
  end

  logic tot_lt, num_lt, num_eq;
  fpm_order u_order (
    .ia(info[0]), .ib(info[1]),
    .tot_lt(tot_lt), .num_lt(num_lt), .num_eq(num_eq));

  logic [XW-1:0] sj_res;
  logic          sj_ok;
  fpm_sgnj u_sgnj (
    .dbl(dbl), .sub(sub), .a(src_a),
    .sgn_a(info[0].sgn), .sgn_b(info[1].sgn),
    .res(sj_res), .ok(sj_ok));

  logic [XW-1:0] mm_res;
  logic          mm_nv, mm_ok;
  fpm_minmax u_minmax (
    .dbl(dbl), .sub(sub), .ia(info[0]), .ib(info[1]),
    .a_fp(fpv[0]), .b_fp(fpv[1]), .tot_lt(tot_lt),
    .res(mm_res), .nv(mm_nv), .ok(mm_ok));

  // compare group
  logic any_nan, any_snan;
  logic cmp_bit, cmp_nv, cmp_ok;
  assign any_snan = info[0].is_snan | info[1].is_snan;
  assign any_nan  = any_snan | info[0].is_qnan | info[1].is_qnan;

  always_comb begin
    cmp_ok  = 1'b1;
    cmp_bit = 1'b0;
    cmp_nv  = 1'b0;
    case (sub)
      3'd0: begin cmp_bit = ~any_nan & (num_lt | num_eq); cmp_nv = any_nan;  end
      3'd1: begin cmp_bit = ~any_nan & num_lt;            cmp_nv = any_nan;  end
      3'd2: begin cmp_bit = ~any_nan & num_eq;            cmp_nv = any_snan; end
      default: cmp_ok = 1'b0;
    endcase
  end

  // classify / move group
  logic [CLS_W-1:0] cls_mask;
  logic [XW-1:0]    cls_res;
  logic             cls_ok;
  opinfo_t          ca;
  assign ca = info[0];

  always_comb begin
    cls_mask    = '0;
    cls_mask[0] = ca.is_inf  &  ca.sgn;
    cls_mask[1] = ca.is_norm &  ca.sgn;
    cls_mask[2] = ca.is_sub  &  ca.sgn;
    cls_mask[3] = ca.is_zero &  ca.sgn;
    cls_mask[4] = ca.is_zero & ~ca.sgn;
    cls_mask[5] = ca.is_sub  & ~ca.sgn;
    cls_mask[6] = ca.is_norm & ~ca.sgn;
    cls_mask[7] = ca.is_inf  & ~ca.sgn;
    cls_mask[8] = ca.is_snan;
    cls_mask[9] = ca.is_qnan;
  end

  always_comb begin
    cls_ok  = 1'b1;
    cls_res = '0;
    case (sub)
      3'd0: cls_res = dbl ? src_a
                          : {{(XW-SP_W){src_a[SP_W-1]}}, src_a[SP_W-1:0]};
      3'd1: cls_res = XW'(cls_mask);
      default: cls_ok = 1'b0;
    endcase
  end

  // next-state selection
  logic [XW-1:0] nxt_res;
  logic          nxt_fp, nxt_int, nxt_nv;

  always_comb begin
    nxt_res = '0;
    nxt_fp  = 1'b0;
    nxt_int = 1'b0;
    nxt_nv  = 1'b0;
    if (in_valid) begin
      case (grp_e'(op))
        GRP_SGNJ: begin
          nxt_res = sj_res;
          nxt_fp  = sj_ok;
        end
        GRP_MINMAX: begin
          nxt_res = mm_res;
          nxt_fp  = mm_ok;
          nxt_nv  = mm_nv;
        end
        GRP_CMP: begin
          nxt_res = cmp_ok ? XW'(cmp_bit) : '0;
          nxt_int = cmp_ok;
          nxt_nv  = cmp_ok & cmp_nv;
        end
        default: begin
          nxt_res = cls_res;
          nxt_int = cls_ok;
        end
      endcase
    end
  end

  // output register stage
  logic ld_en;
  assign ld_en = in_valid | out_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= in_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result  <= '0;
      fp_wr   <= 1'b0;
      int_wr  <= 1'b0;
      flag_nv <= 1'b0;
    end else if (ld_en) begin
      result  <= nxt_res;
      fp_wr   <= nxt_fp;
      int_wr  <= nxt_int;
      flag_nv <= nxt_nv;
    end
  end

endmodule

// File: rtl/fpm_unit_chk.sv
module fpm_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        dbl,
  input logic [1:0]  op,
  input logic [2:0]  sub,
  input logic        out_valid,
  input logic        fp_wr,
  input logic        int_wr,
  input logic [63:0] result,
  input logic        flag_nv
);

  // R11: no write or flag without a presented result
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (!fp_wr && !int_wr && !flag_nv));

  // R8: never both destinations
  a_r8_one_dest: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(fp_wr && int_wr));

  // R1: classification mask has exactly one bit in the low ten
  a_r1_class_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(op) == 2'd3 && $past(sub) == 3'd1)
      |-> ($countones(result) == 1 && result[63:10] == 54'd0));

  // R6: sign injection never flags
  a_r6_sgnj_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(op) == 2'd0) |-> !flag_nv);

  // R9: single-precision move is sign-extended
  a_r9_move_sext: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(op) == 2'd3 && $past(sub) == 3'd0 && !$past(dbl))
      |-> (result[63:32] == {32{result[31]}}));

  // R2 / R3: compare result is a single bit
  a_r3_cmp_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(op) == 2'd2) |-> (result[63:1] == 63'd0));

  // R10: unused min/max sub-select does nothing
  a_r10_bad_sub: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(op) == 2'd1 && $past(sub) > 3'd1)
      |-> (!fp_wr && !int_wr && !flag_nv && result == 64'd0));

endmodule

bind fpm_unit fpm_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .dbl(dbl), .op(op), .sub(sub),
  .out_valid(out_valid), .fp_wr(fp_wr), .int_wr(int_wr),
  .result(result), .flag_nv(flag_nv));

// File: tb/fpm_unit_test.sv
`timescale 1ns/1ps
module fpm_unit_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic        dbl;
  logic [1:0]  op;
  logic [2:0]  sub;
  logic [63:0] src_a, src_b;
  logic        out_valid, fp_wr, int_wr, flag_nv;
  logic [63:0] result;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #2 clk = ~clk;

  fpm_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .dbl(dbl), .op(op),
    .sub(sub), .src_a(src_a), .src_b(src_b), .out_valid(out_valid),
    .fp_wr(fp_wr), .int_wr(int_wr), .result(result), .flag_nv(flag_nv));

  typedef struct packed {
    logic [63:0] r;
    logic        fw;
    logic        iw;
    logic        nv;
  } exp_t;

  // ---------------- reference helpers ----------------
  function automatic logic f_sign(input logic d, input logic [63:0] x);
    return d ? x[63] : x[31];
  endfunction
  function automatic logic f_nan(input logic d, input logic [63:0] x);
    if (d) return (x[62:52] == 11'h7FF) && (x[51:0] != 0);
    return (x[30:23] == 8'hFF) && (x[22:0] != 0);
  endfunction
  function automatic logic f_snan(input logic d, input logic [63:0] x);
    return f_nan(d, x) && !(d ? x[51] : x[22]);
  endfunction
  function automatic logic [63:0] f_low(input logic d, input logic [63:0] x);
    return d ? x : {32'd0, x[31:0]};
  endfunction
  function automatic logic signed [65:0] f_key(input logic d, input logic [63:0] x);
    logic signed [65:0] m;
    m = d ? $signed({3'b000, x[62:0]}) : $signed({35'd0, x[30:0]});
    return f_sign(d, x) ? -m : m;
  endfunction
  function automatic logic [9:0] f_class(input logic d, input logic [63:0] x);
    logic s;
    logic ez, eo, mz;
    s  = f_sign(d, x);
    ez = d ? (x[62:52] == 0) : (x[30:23] == 0);
    eo = d ? (x[62:52] == 11'h7FF) : (x[30:23] == 8'hFF);
    mz = d ? (x[51:0] == 0) : (x[22:0] == 0);
    if (eo && !mz) return f_snan(d, x) ? 10'b01_0000_0000 : 10'b10_0000_0000;
    if (eo)        return s ? 10'd1 : 10'd128;
    if (ez && mz)  return s ? 10'd8 : 10'd16;
    if (ez)        return s ? 10'd4 : 10'd32;
    return s ? 10'd2 : 10'd64;
  endfunction

  function automatic exp_t ref_op(input logic [1:0] o, input logic [2:0] s,
                                  input logic d, input logic [63:0] a,
                                  input logic [63:0] b);
    exp_t e;
    logic na, nb, ns, afirst;
    logic signed [65:0] ka, kb;
    e  = '0;
    na = f_nan(d, a);
    nb = f_nan(d, b);
    ka = f_key(d, a);
    kb = f_key(d, b);
    case (o)
      2'd0: if (s <= 2) begin
        ns = (s == 0) ? f_sign(d, b) : (s == 1) ? !f_sign(d, b)
                                                : (f_sign(d, a) ^ f_sign(d, b));
        e.r  = d ? {ns, a[62:0]} : {32'd0, ns, a[30:0]};
        e.fw = 1;
      end
      2'd1: if (s <= 1) begin
        e.fw = 1;
        e.nv = f_snan(d, a) || f_snan(d, b);
        if (na && nb)  e.r = d ? 64'h7FF8_0000_0000_0000 : 64'h0000_0000_7FC0_0000;
        else if (na)   e.r = f_low(d, b);
        else if (nb)   e.r = f_low(d, a);
        else begin
          afirst = (ka < kb) || (ka == kb && f_sign(d, a) && !f_sign(d, b));
          e.r = ((s == 0) == afirst) ? f_low(d, a) : f_low(d, b);
        end
      end
      2'd2: if (s <= 2) begin
        e.iw = 1;
        if (s == 2) begin
          e.nv = f_snan(d, a) || f_snan(d, b);
          e.r  = {63'd0, !na && !nb && ka == kb};
        end else begin
          e.nv = na || nb;
          e.r  = {63'd0, !na && !nb && ((s == 1) ? (ka < kb) : (ka <= kb))};
        end
      end
      default: if (s == 0) begin
        e.iw = 1;
        e.r  = d ? a : {{32{a[31]}}, a[31:0]};
      end else if (s == 1) begin
        e.iw = 1;
        e.r  = {54'd0, f_class(d, a)};
      end
    endcase
    return e;
  endfunction

  function automatic string tag_of(input logic [1:0] o, input logic [2:0] s);
    case (o)
      2'd0: return (s <= 2) ? "R6" : "R10";
      2'd1: return (s <= 1) ? "R4/R5" : "R10";
      2'd2: return (s == 2) ? "R2" : (s < 2) ? "R3" : "R10";
      default: return (s == 0) ? "R9" : (s == 1) ? "R1" : "R10";
    endcase
  endfunction

  // biased operand generator
  function automatic logic [63:0] gen(input logic d, input logic [63:0] other);
    int unsigned k;
    logic [51:0] m;
    logic [10:0] e;
    logic        s;
    logic [31:0] hi;
    k  = $urandom % 10;
    m  = {$urandom, $urandom};
    e  = 11'($urandom);
    s  = 1'($urandom);
    hi = $urandom;
    case (k)
      3: begin e = 0; m = 0; end
      4: begin e = 11'h7FF; m = 0; end
      5: begin e = 11'h7FF; if (d) m[51] = 1; else m[22] = 1; end
      6: begin e = 11'h7FF; if (d) m[51] = 0; else m[22] = 0; m[0] = 1; end
      7: begin e = 0; m[0] = 1; end
      8: return other;
      9: return d ? {~other[63], other[62:0]} : {other[63:32], ~other[31], other[30:0]};
      default: ;
    endcase
    if (d) return {s, e, m};
    return {hi, s, e[7:0], m[22:0]};
  endfunction

  task automatic run_op(input logic [1:0] o, input logic [2:0] s, input logic d,
                        input logic [63:0] a, input logic [63:0] b, input string tag);
    exp_t e;
    e        = ref_op(o, s, d, a, b);
    op       = o;
    sub      = s;
    dbl      = d;
    src_a    = a;
    src_b    = b;
    in_valid = 1'b1;
    @(negedge clk);
    n_checks++;
    if (out_valid !== 1'b1 || result !== e.r || fp_wr !== e.fw ||
        int_wr !== e.iw || flag_nv !== e.nv) begin
      n_fail++;
      $display("FAIL %s op=%0d sub=%0d dbl=%0b a=%h b=%h got v=%b res=%h fw=%b iw=%b nv=%b exp v=1 res=%h fw=%b iw=%b nv=%b",
               tag, o, s, d, a, b, out_valid, result, fp_wr, int_wr, flag_nv,
               e.r, e.fw, e.iw, e.nv);
    end
  endtask

  task automatic check_val(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  localparam logic [63:0] D_ONE  = 64'h3FF0_0000_0000_0000;
  localparam logic [63:0] D_NZ   = 64'h8000_0000_0000_0000;
  localparam logic [63:0] D_QN   = 64'h7FF8_0000_0000_1234;
  localparam logic [63:0] D_SN   = 64'h7FF0_0000_0000_0001;
  localparam logic [63:0] S_ONE  = 64'h0000_0000_3F80_0000;
  localparam logic [63:0] S_QN   = 64'h0000_0000_7FC0_0055;
  localparam logic [63:0] S_SN   = 64'h0000_0000_7F80_0001;

  initial begin
    logic [63:0] cls_d [10];
    logic [63:0] cls_s [10];
    int unsigned seed_set;
    seed_set = $urandom(32'd4242);
    rst_n = 1'b0; in_valid = 0; dbl = 0; op = 0; sub = 0; src_a = 0; src_b = 0;
    repeat (3) @(negedge clk);
    // R11 reset state
    check_val("R11 reset", {out_valid, fp_wr, int_wr, flag_nv, result[59:0]}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 classify all ten classes
    cls_d = '{64'hFFF0_0000_0000_0000, 64'hBFF0_0000_0000_0000, 64'h8000_0000_0000_0001,
              D_NZ, 64'd0, 64'h0000_0000_0000_0001, D_ONE, 64'h7FF0_0000_0000_0000,
              D_SN, D_QN};
    cls_s = '{64'hFF80_0000, 64'hBF80_0000, 64'h8000_0001, 64'h8000_0000, 64'h0,
              64'h0000_0001, S_ONE, 64'h7F80_0000, S_SN, S_QN};
    for (int i = 0; i < 10; i++) begin
      run_op(2'd3, 3'd1, 1'b1, cls_d[i], 64'd0, "R1");
      check_val("R1 mask double", result, 64'd1 << i);
      run_op(2'd3, 3'd1, 1'b0, cls_s[i] | 64'hABCD_0000_0000_0000, 64'd0, "R1");
      check_val("R1 mask single", result, 64'd1 << i);
    end

    // R2 equal
    run_op(2'd2, 3'd2, 1'b1, 64'd0, D_NZ, "R2 +0==-0");
    check_val("R2 zero eq", result, 64'd1);
    run_op(2'd2, 3'd2, 1'b1, D_QN, D_ONE, "R2 qnan");
    check_val("R2 qnan no flag", {63'd0, flag_nv}, 64'd0);
    run_op(2'd2, 3'd2, 1'b0, S_ONE, S_SN, "R2 snan");
    check_val("R2 snan flag", {63'd0, flag_nv}, 64'd1);

    // R3 ordered compares
    run_op(2'd2, 3'd1, 1'b1, D_QN, D_ONE, "R3 lt qnan");
    check_val("R3 qnan flag", {63'd0, flag_nv}, 64'd1);
    run_op(2'd2, 3'd0, 1'b0, S_ONE, S_ONE, "R3 le eq");
    run_op(2'd2, 3'd1, 1'b1, D_NZ, 64'd0, "R3 lt -0,+0");
    check_val("R3 -0 not below +0", result, 64'd0);

    // R4 / R5 min-max
    run_op(2'd1, 3'd0, 1'b1, 64'd0, D_NZ, "R4 min zeros");
    check_val("R4 min -0", result, D_NZ);
    run_op(2'd1, 3'd1, 1'b1, D_NZ, 64'd0, "R4 max zeros");
    check_val("R4 max +0", result, 64'd0);
    run_op(2'd1, 3'd0, 1'b1, D_SN, D_ONE, "R4 snan");
    check_val("R4 snan flag", {63'd0, flag_nv}, 64'd1);
    run_op(2'd1, 3'd1, 1'b0, S_ONE, S_QN, "R4 qnan");
    run_op(2'd1, 3'd0, 1'b1, D_QN, D_SN, "R5 both nan");
    check_val("R5 canon double", result, 64'h7FF8_0000_0000_0000);
    run_op(2'd1, 3'd1, 1'b0, S_QN, S_QN, "R5 both nan");
    check_val("R5 canon single", result, 64'h0000_0000_7FC0_0000);

    // R6 sign injection keeps payload
    run_op(2'd0, 3'd2, 1'b1, D_SN, D_NZ, "R6 payload");
    check_val("R6 payload", result, 64'hFFF0_0000_0000_0001);

    // R7 single ignores upper bits, FP results zero on top
    run_op(2'd0, 3'd1, 1'b0, S_ONE | 64'hFFFF_FFFF_0000_0000,
           64'h1234_5678_0000_0000, "R7 upper");
    check_val("R7 upper zero", result, 64'h0000_0000_BF80_0000);

    // R8 destination selects
    run_op(2'd1, 3'd0, 1'b1, D_ONE, 64'd0, "R8");
    check_val("R8 fp dest", {62'd0, fp_wr, int_wr}, 64'd2);
    run_op(2'd2, 3'd0, 1'b1, D_ONE, 64'd0, "R8");
    check_val("R8 int dest", {62'd0, fp_wr, int_wr}, 64'd1);

    // R9 moves
    run_op(2'd3, 3'd0, 1'b0, 64'h0000_0000_8000_0001, 64'd0, "R9 sext");
    check_val("R9 sext", result, 64'hFFFF_FFFF_8000_0001);
    run_op(2'd3, 3'd0, 1'b1, 64'h8123_4567_89AB_CDEF, 64'd0, "R9 copy");

    // R10 unused sub-selects
    run_op(2'd0, 3'd3, 1'b1, D_SN, D_SN, "R10");
    run_op(2'd1, 3'd5, 1'b1, D_SN, D_ONE, "R10");
    run_op(2'd2, 3'd3, 1'b0, S_SN, S_QN, "R10");
    run_op(2'd3, 3'd7, 1'b1, D_ONE, D_ONE, "R10");

    // R11 idle after a flagged result
    run_op(2'd2, 3'd1, 1'b1, D_SN, D_ONE, "R11 pre");
    in_valid = 1'b0;
    @(negedge clk);
    check_val("R11 idle", {61'd0, out_valid, fp_wr, int_wr | flag_nv}, 64'd0);

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      logic d;
      logic [63:0] a, b;
      logic [1:0]  o;
      logic [2:0]  s;
      d = 1'($urandom);
      a = gen(d, 64'h3FF0_0000_3F80_0000);
      b = gen(d, a);
      o = 2'($urandom);
      s = ($urandom % 8 == 0) ? 3'($urandom) : 3'($urandom % 3);
      run_op(o, s, d, a, b, tag_of(o, s));
    end
    in_valid = 1'b0;
    @(negedge clk);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL R11 watchdog expired got=hang exp=finish");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

endmodule